// File: doc/BRIEF.md
# Dual-Width ALU with Status Flags

This block is an arithmetic and logic unit with registered outputs. Each operation works on either byte (8-bit) or word (16-bit) operands; a width input picks the size for every operation on its own. The operation set is add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR and pass-through of the second operand. The result goes into a result register. Six condition flags go into a 16-bit status word: carry, auxiliary carry, even parity, zero, sign and overflow.

The same status word also holds three control flags: interrupt enable, string direction and single-step trap. A separate command input sets or clears each of them. An operation and a command may be issued in the same cycle. The operation updates only the condition bits and the command updates only its own control bit, so neither disturbs the other. Carry-in for add-with-carry, and borrow-in for subtract-with-borrow, come from the stored carry flag.

Top module: `dual_width_alu`

## Requirements
- R1: While reset is held low, and after it is released but before any operation or command, `result` and `status` both read 0x0000.
- R2: `alu_op` encoding: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 pass `opnd_b`. With `wide`=1 all 16 bits are used. With `wide`=0 only bits 7:0 of each operand are used, and `result[15:8]` reads zero.
- R3: The carry flag (status bit 0) is the carry out of the operand's top bit (bit 15 or bit 7) on add. On subtract it is the borrow into that bit.
- R4: The auxiliary carry flag (status bit 4) is the carry, or the borrow, between bit 3 and bit 4 of an arithmetic operation.
- R5: The parity flag (status bit 2) is 1 when bits 7:0 of the result hold an even number of ones, and 0 otherwise. This holds in both widths.
- R6: The zero flag (status bit 6) is 1 when the result at the selected width is zero. The sign flag (status bit 7) copies bit 15 of the result in word mode and bit 7 in byte mode.
- R7: The overflow flag (status bit 11) is 1 when a signed add or subtract at the selected width falls outside the representable range.
- R8: Add-with-carry adds the stored carry flag. Subtract-with-borrow also subtracts the stored carry flag.
- R9: AND, OR, XOR and pass-through leave carry, overflow and auxiliary carry at 0.
- R10: Status layout: trap 8, interrupt enable 9, direction 10, with the condition bits as above. Bits 1, 3, 5 and 12 to 15 always read 0.
- R11: `ctl_cmd` encoding: 0 none, 1 set interrupt enable, 2 clear it, 3 set direction, 4 clear it, 5 set trap, 6 clear it, 7 no effect. A command changes only its own bit. Operations never change control bits.
- R12: While `op_valid` is low, `result` and the condition flags hold their values, whatever the operand, width and opcode inputs do.
- R13: The result and flags of an operation accepted on one rising edge can be read from that edge until the next accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Performs the operation on this edge |
| alu_op | input | 3 | Operation code |
| wide | input | 1 | 1 selects word, 0 selects byte |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| ctl_cmd | input | 3 | Control flag command |
| result | output | 16 | Registered result |
| status | output | 16 | Status word |

## Verification
The properties assume that `alu_op`, `wide` and `ctl_cmd` are always known values. They also assume that a command arriving together with an operation is meant to apply on the same edge. Reset is taken to be synchronous, so each property reads registered values only from the first edge after reset is released. The stimulus changes inputs only on falling clock edges and always drives defined codes, including the spare command code 7. Operands carry nonzero upper bytes during byte operations so that their exclusion can be seen.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = WORD_W / 2;
  localparam int NIB_W  = 4;
  localparam int ST_W   = 16;

  localparam int CF_B = 0;
  localparam int PF_B = 2;
  localparam int AF_B = 4;
  localparam int ZF_B = 6;
  localparam int SF_B = 7;
  localparam int TF_B = 8;
  localparam int IE_B = 9;
  localparam int DF_B = 10;
  localparam int OF_B = 11;

  localparam logic [ST_W-1:0] COND_MASK =
    ST_W'((1 << CF_B) | (1 << PF_B) | (1 << AF_B) | (1 << ZF_B) | (1 << SF_B) | (1 << OF_B));

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_PASS = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0, CMD_SET_IE = 3'd1, CMD_CLR_IE = 3'd2, CMD_SET_DF = 3'd3,
    CMD_CLR_DF = 3'd4, CMD_SET_TF = 3'd5, CMD_CLR_TF = 3'd6, CMD_SPARE = 3'd7
  } ctl_cmd_e;

  typedef struct packed {
    word_t res;
    logic  cf;
    logic  af;
    logic  of;
  } arith_t;

  function automatic word_t narrow(word_t v, logic wide);
    return wide ? v : {{(WORD_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
  endfunction

  // Add or subtract at the chosen width, with carry or borrow in
  function automatic arith_t arith_eval(word_t a, word_t b, logic sub, logic cin, logic wide);
    arith_t o;
    logic [WORD_W:0] ea, eb, ec, full;
    logic [NIB_W:0]  nib;
    logic sa, sb, sr;
    ea = {1'b0, narrow(a, wide)};
    eb = {1'b0, narrow(b, wide)};
    ec = {{WORD_W{1'b0}}, cin};
    full = sub ? (ea - eb - ec) : (ea + eb + ec);
    nib = sub ? ({1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin})
              : ({1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin});
    o.af = nib[NIB_W];
    if (wide) begin
      o.res = full[WORD_W-1:0];
      o.cf  = full[WORD_W];
      sa = a[WORD_W-1]; sb = b[WORD_W-1]; sr = full[WORD_W-1];
    end else begin
      o.res = {{(WORD_W-BYTE_W){1'b0}}, full[BYTE_W-1:0]};
      o.cf  = full[BYTE_W];
      sa = a[BYTE_W-1]; sb = b[BYTE_W-1]; sr = full[BYTE_W-1];
    end
    o.of = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    return o;
  endfunction

  function automatic word_t logic_eval(word_t a, word_t b, logic [1:0] sel, logic wide);
    word_t r;
    case (sel)
      2'd0:    r = a & b;
      2'd1:    r = a | b;
      2'd2:    r = a ^ b;
      default: r = b;
    endcase
    return narrow(r, wide);
  endfunction

  function automatic logic even_ones(logic [BYTE_W-1:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/dwalu_arith.sv
module dwalu_arith
  import dwalu_pkg::*;
(
  input  word_t a,
  input  word_t b,
  input  logic  sub,
  input  logic  cin,
  input  logic  wide,
  output word_t res,
  output logic  cf,
  output logic  af,
  output logic  of
);
  arith_t r;
  always_comb begin
    r   = arith_eval(a, b, sub, cin, wide);
    res = r.res;
    cf  = r.cf;
    af  = r.af;
    of  = r.of;
  end
endmodule

// File: rtl/dwalu_logic.sv
module dwalu_logic
  import dwalu_pkg::*;
(
  input  word_t      a,
  input  word_t      b,
  input  logic [1:0] sel,
  input  logic       wide,
  output word_t      res
);
  always_comb res = logic_eval(a, b, sel, wide);
endmodule

// File: rtl/dwalu_flags.sv
module dwalu_flags
  import dwalu_pkg::*;
(
  input  word_t            res,
  input  logic             wide,
  input  logic             is_arith,
  input  logic             cf,
  input  logic             af,
  input  logic             of,
  output logic [ST_W-1:0]  cond
);
  logic zf, sf, pf;
  always_comb begin
    zf = (res == '0);
    sf = wide ? res[WORD_W-1] : res[BYTE_W-1];
    pf = even_ones(res[BYTE_W-1:0]);
    cond       = '0;
    cond[CF_B] = is_arith & cf;
    cond[AF_B] = is_arith & af;
    cond[OF_B] = is_arith & of;
    cond[ZF_B] = zf;
    cond[SF_B] = sf;
    cond[PF_B] = pf;
  end
endmodule

// File: rtl/dwalu_status.sv
module dwalu_status
  import dwalu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_cond,
  input  logic [ST_W-1:0] cond_in,
  input  logic [2:0]      cmd,
  output logic [ST_W-1:0] st
);
  logic [ST_W-1:0] st_d;
  always_comb begin
    st_d = st;
    if (upd_cond) st_d = (st & ~COND_MASK) | (cond_in & COND_MASK);
    case (ctl_cmd_e'(cmd))
      CMD_SET_IE: st_d[IE_B] = 1'b1;
      CMD_CLR_IE: st_d[IE_B] = 1'b0;
      CMD_SET_DF: st_d[DF_B] = 1'b1;
      CMD_CLR_DF: st_d[DF_B] = 1'b0;
      CMD_SET_TF: st_d[TF_B] = 1'b1;
      CMD_CLR_TF: st_d[TF_B] = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= st_d;
  end
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
  import dwalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        alu_op,
  input  logic              wide,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [2:0]        ctl_cmd,
  output logic [WORD_W-1:0] result,
  output logic [ST_W-1:0]   status
);
  // Named internal events, visible to the bound checker
  logic  is_arith, is_sub, carry_in;
  word_t arith_res, logic_res, sel_res;
  logic  arith_cf, arith_af, arith_of;
  logic [ST_W-1:0] cond_flags;

  assign is_arith = ~alu_op[2];
  assign is_sub   = alu_op[1];
  assign carry_in = alu_op[0] & status[CF_B];

  dwalu_arith u_arith (
    .a(opnd_a), .b(opnd_b), .sub(is_sub), .cin(carry_in), .wide(wide),
    .res(arith_res), .cf(arith_cf), .af(arith_af), .of(arith_of)
  );

  dwalu_logic u_logic (
    .a(opnd_a), .b(opnd_b), .sel(alu_op[1:0]), .wide(wide), .res(logic_res)
  );

  assign sel_res = is_arith ? arith_res : logic_res;

  dwalu_flags u_flags (
    .res(sel_res), .wide(wide), .is_arith(is_arith),
    .cf(arith_cf), .af(arith_af), .of(arith_of), .cond(cond_flags)
  );

  dwalu_status u_status (
    .clk(clk), .rst_n(rst_n), .upd_cond(op_valid), .cond_in(cond_flags),
    .cmd(ctl_cmd), .st(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        result <= '0;
    else if (op_valid) result <= sel_res;
  end
endmodule

// File: rtl/dwalu_checker.sv
module dwalu_checker
  import dwalu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        alu_op,
  input logic              wide,
  input logic [2:0]        ctl_cmd,
  input logic [WORD_W-1:0] result,
  input logic [ST_W-1:0]   status
);
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & 16'hF02A) == 16'h0000);

  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !wide |=> result[WORD_W-1:BYTE_W] == '0);

  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> status[PF_B] == ~^result[BYTE_W-1:0]);

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> status[ZF_B] == (result == '0));

  assert_sign_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && wide |=> status[SF_B] == result[WORD_W-1]);

  assert_sign_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !wide |=> status[SF_B] == result[BYTE_W-1]);

  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && alu_op[2] |=> !status[CF_B] && !status[OF_B] && !status[AF_B]);

  assert_set_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd == 3'd1 |=> status[IE_B]);

  assert_clr_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd == 3'd2 |=> !status[IE_B]);

  assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd == 3'd0 |=> $stable(status[DF_B:TF_B]));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result) && $stable(status & COND_MASK));
endmodule

bind dual_width_alu dwalu_checker chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .alu_op(alu_op), .wide(wide),
  .ctl_cmd(ctl_cmd), .result(result), .status(status)
);

// File: tb/dual_width_alu_test.sv
module dual_width_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  alu_op = 3'd0;
  logic        wide = 1'b0;
  logic [15:0] opnd_a = 16'h0, opnd_b = 16'h0;
  logic [2:0]  ctl_cmd = 3'd0;
  logic [15:0] result, status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_width_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .alu_op(alu_op), .wide(wide),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ctl_cmd(ctl_cmd), .result(result), .status(status)
  );

  // {op, wide, a, b, expected result, expected status}; run in order, carry flows on
  localparam int NV = 13;
  localparam logic [67:0] VEC [NV] = '{
    {3'd0, 1'b1, 16'h1234, 16'h4321, 16'h5555, 16'h0004}, // R2 word add
    {3'd0, 1'b0, 16'h12FF, 16'h0001, 16'h0000, 16'h0055}, // R3 R4 R6 byte carry out
    {3'd1, 1'b1, 16'h0001, 16'h0001, 16'h0003, 16'h0004}, // R8 adc uses CF=1
    {3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 16'h0894}, // R7 word overflow
    {3'd2, 1'b0, 16'h0010, 16'h0001, 16'h000F, 16'h0014}, // R4 nibble borrow
    {3'd2, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 16'h0095}, // R3 word borrow
    {3'd3, 1'b1, 16'h0005, 16'h0002, 16'h0002, 16'h0000}, // R8 sbb uses CF=1
    {3'd2, 1'b0, 16'h0080, 16'h0001, 16'h007F, 16'h0810}, // R7 byte sub overflow
    {3'd4, 1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0004}, // R9 and
    {3'd5, 1'b0, 16'h1280, 16'h3401, 16'h0081, 16'h0084}, // R9 byte or
    {3'd6, 1'b1, 16'hAAAA, 16'hAAAA, 16'h0000, 16'h0044}, // R6 xor zero
    {3'd7, 1'b1, 16'h5555, 16'h8001, 16'h8001, 16'h0080}, // R5 pass, odd low byte
    {3'd0, 1'b0, 16'hFF7F, 16'h0001, 16'h0080, 16'h0890}  // R7 byte add overflow
  };

  task automatic check16(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Inputs change at the falling edge; the next rising edge accepts them;
  // the following falling edge samples.
  task automatic step(logic v, logic [2:0] op, logic w, logic [15:0] a, logic [15:0] b,
                      logic [2:0] cmd);
    @(negedge clk);
    op_valid = v; alu_op = op; wide = w; opnd_a = a; opnd_b = b; ctl_cmd = cmd;
    @(negedge clk);
    op_valid = 1'b0; ctl_cmd = 3'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check16("R1", "result in reset", result, 16'h0000);
    check16("R1", "status in reset", status, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check16("R1", "result after reset", result, 16'h0000);
    check16("R1", "status after reset", status, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][67:65], VEC[i][64], VEC[i][63:48], VEC[i][47:32], 3'd0);
      check16("R13", $sformatf("vector %0d result", i), result, VEC[i][31:16]);
      check16("R3-R7", $sformatf("vector %0d status", i), status, VEC[i][15:0]);
    end

    // R11: commands alone and together with an operation
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd1);
    check16("R11", "set interrupt enable", status, 16'h0A90);
    check16("R11", "result kept by command", result, 16'h0080);
    step(1'b1, 3'd0, 1'b1, 16'h0001, 16'h0001, 3'd3);
    check16("R11", "set direction with add", status, 16'h0600);
    check16("R11", "result of add with command", result, 16'h0002);
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd5);
    check16("R11", "set trap", status, 16'h0700);
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd2);
    check16("R11", "clear interrupt enable", status, 16'h0500);

    // R12: idle cycles with moving inputs
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 3'(k + 4), k[0], 16'hFFFF - 16'(k), 16'h1357 + 16'(k), 3'd0);
    end
    check16("R12", "idle result hold", result, 16'h0002);
    check16("R12", "idle status hold", status, 16'h0500);
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd7);
    check16("R11", "spare command code 7", status, 16'h0500);

    // R10: ops leave control bits, unused bits stay zero with all set
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd1);
    step(1'b1, 3'd2, 1'b1, 16'h0000, 16'h0001, 3'd3);
    check16("R10", "all control plus borrow flags", status, 16'h0795);
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd4);
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd6);
    step(1'b0, 3'd0, 1'b1, 16'h0, 16'h0, 3'd2);
    check16("R11", "all control cleared", status, 16'h0095);

    // R1: reset in mid run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check16("R1", "result after mid reset", result, 16'h0000);
    check16("R1", "status after mid reset", status, 16'h0000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule